// File: doc/BRIEF.md
# Four-Channel Auto-Reload PWM Generator

The block produces four pulse-width-modulated outputs from one shared 8-bit up-counter. On every cycle where the tick input is high, the counter advances by one. When it passes its top value, it restarts from a programmable reload value. Every channel therefore shares the same period, and every channel's first edge falls at the reload point. Each channel's second edge is set by its own compare value.

Software reaches the block through a plain register port: a write strobe, an address, write data and combinational readback. One control register holds an enable bit and a polarity bit for each channel. One register holds the shared reload value, and each channel has its own duty register. A written duty value waits in a shadow register. It reaches the channel's active compare register only when the counter reloads, so a period already under way is never cut short and never gains an extra edge. A polarity change, by contrast, takes effect on the next cycle.

Top module: `quad_reload_pwm`

## Requirements
- R1: After reset, the control, reload and duty registers read 00h, the counter is 0, every active compare value is 0 and all four outputs are 0.
- R2: The address map is as follows. Address 0 is control, with enables for channels 3..0 in bits 7:4 and polarities for channels 3..0 in bits 3:0. Address 1 is the reload value. Addresses 4+n are the duty registers for channel n. A write takes effect at the clock edge and reads back unchanged. Addresses 2 and 3 read 00h, and writes to them change nothing.
- R3: On a cycle with tick high and the counter below FFh, the counter increases by one. On a cycle with tick low, it holds its value.
- R4: On a cycle with tick high and the counter at FFh, the counter loads the reload value. The output period is therefore 256 minus the reload value, counted in ticks.
- R5: A channel's active compare value is loaded from its duty register only on a reload cycle (tick high with the counter at FFh). A duty write in mid-period leaves the current waveform unchanged.
- R6: For an enabled channel with polarity 0, the output is 1 while the counter is less than or equal to the active compare value, and 0 otherwise.
- R7: For an enabled channel with polarity 1, the output is 0 while the counter is less than or equal to the active compare value, and 1 otherwise.
- R8: A channel with enable 0 drives 0 whatever its polarity. The counter and the compare loading keep running while the channel is disabled.
- R9: A write that flips a channel's polarity bit inverts that output from the cycle after the write edge, with no wait for a reload.
- R10: An enabled channel whose active compare value is below the reload value holds its above-compare level for the whole period. A compare value of FFh holds the at-or-below level for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Readback of the addressed register |
| pwm_out | output | 4 | PWM outputs, bit n is channel n |

## Verification
The assertions assume that tick_en, wr_en, addr and wdata are stable, known values at every rising clock edge once reset is released. They also assume a register write is a single-cycle event, with no constraint on its timing relative to the counter. The bench changes all inputs only at falling edges. It draws addresses over the full 3-bit range, unmapped ones included, and holds tick high about three cycles in four, so that reloads occur both with and without concurrent writes. Reload values are drawn at random, so periods vary from 1 to 256 ticks and compare values fall both above and below the reload value.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;

    // Register groups selected by the decoded address
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_DUTY   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/qpwm_regs.sv
module qpwm_regs
    import qpwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [CNT_W-1:0]               wdata,
    output logic [CNT_W-1:0]               rdata,
    output logic [NUM_CH-1:0]              ch_en,
    output logic [NUM_CH-1:0]              ch_pol,
    output logic [CNT_W-1:0]               reload,
    output logic [NUM_CH-1:0][CNT_W-1:0]   duty
);

    localparam int IDX_W     = ADDR_W - 1;
    localparam int DUTY_BASE = 1 << IDX_W;

    typedef struct packed {
        logic [NUM_CH-1:0]            en;
        logic [NUM_CH-1:0]            pol;
        logic [CNT_W-1:0]             reload;
        logic [NUM_CH-1:0][CNT_W-1:0] duty;
    } regs_t;

    regs_t          st_d, st_q;
    reg_sel_e       sel;
    logic [IDX_W-1:0] idx;

    // Address decode
    always_comb begin
        idx = addr[IDX_W-1:0];
        if (int'(addr) >= DUTY_BASE) begin
            sel = (int'(idx) < NUM_CH) ? SEL_DUTY : SEL_NONE;
        end else if (addr == ADDR_W'(0)) begin
            sel = SEL_CTRL;
        end else if (addr == ADDR_W'(1)) begin
            sel = SEL_RELOAD;
        end else begin
            sel = SEL_NONE;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (sel)
                SEL_CTRL: begin
                    st_d.en  = wdata[NUM_CH +: NUM_CH];
                    st_d.pol = wdata[0 +: NUM_CH];
                end
                SEL_RELOAD: st_d.reload   = wdata;
                SEL_DUTY:   st_d.duty[idx] = wdata;
                default:    st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Readback
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CTRL: begin
                rdata[NUM_CH +: NUM_CH] = st_q.en;
                rdata[0 +: NUM_CH]      = st_q.pol;
            end
            SEL_RELOAD: rdata = st_q.reload;
            SEL_DUTY:   rdata = st_q.duty[idx];
            default:    rdata = '0;
        endcase
    end

    assign ch_en  = st_q.en;
    assign ch_pol = st_q.pol;
    assign reload = st_q.reload;
    assign duty   = st_q.duty;

    // R2: a control write lands on the next cycle
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0)) |=>
            (ch_en == $past(wdata[NUM_CH +: NUM_CH]) && ch_pol == $past(wdata[0 +: NUM_CH])));

    // R2: unmapped addresses leave every register unchanged
    assert_unmapped_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(2) || addr == ADDR_W'(3)) |=>
            ($stable(ch_en) && $stable(ch_pol) && $stable(reload) && $stable(duty)));

    // R2: the reload register changes only through its own address
    assert_reload_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(1)) |=> $stable(reload));

endmodule

// File: rtl/qpwm_counter.sv
module qpwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = tick && (st_q.cnt == CNT_TOP);
        if (wrap)      st_d.cnt = reload;
        else if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R3: ordinary tick steps by one
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != CNT_TOP) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R3: no tick, no movement
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    // R4: at the top the counter restarts from the reload value
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == CNT_TOP) |=> (cnt == $past(reload)));

endmodule

// File: rtl/qpwm_channel.sv
module qpwm_channel #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] duty,
    input  logic [CNT_W-1:0] cnt,
    input  logic             en,
    input  logic             pol,
    output logic             pwm
);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   at_or_below;

    always_comb begin
        st_d = st_q;
        if (load) st_d.cmp = duty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Polarity is applied after the compare, so a flip acts at once
    always_comb begin
        at_or_below = (cnt <= st_q.cmp);
        pwm         = en && (at_or_below ^ pol);
    end

    // R5: the active compare only moves on a reload
    assert_cmp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.cmp));

    assert_cmp_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.cmp == $past(duty)));

    // R8: disabled channel is quiet
    assert_disabled_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwm);

endmodule

// File: rtl/quad_reload_pwm.sv
module quad_reload_pwm
    import qpwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [NUM_CH-1:0]            ch_en;
    logic [NUM_CH-1:0]            ch_pol;
    logic [CNT_W-1:0]             reload;
    logic [NUM_CH-1:0][CNT_W-1:0] duty;
    logic [CNT_W-1:0]             cnt;
    logic                         wrap;

    qpwm_regs #(
        .CNT_W (CNT_W),
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .ch_en (ch_en),
        .ch_pol(ch_pol),
        .reload(reload),
        .duty  (duty)
    );

    qpwm_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_en),
        .reload(reload),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        qpwm_channel #(
            .CNT_W(CNT_W)
        ) u_ch (
            .clk  (clk),
            .rst_n(rst_n),
            .load (wrap),
            .duty (duty[g]),
            .cnt  (cnt),
            .en   (ch_en[g]),
            .pol  (ch_pol[g]),
            .pwm  (pwm_out[g])
        );
    end

    // R9: a polarity flip on an enabled, otherwise quiet channel inverts its output
    for (genvar g = 0; g < NUM_CH; g++) begin : g_pol_chk
        assert_pol_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($changed(ch_pol[g]) && ch_en[g] && $stable(ch_en[g]) && $stable(cnt))
                |-> (pwm_out[g] != $past(pwm_out[g])));
    end

    // R4: a reload cycle always brings the counter to the reload value
    assert_wrap_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt == CNT_TOP) |=> (cnt == $past(reload)));

endmodule

// File: tb/test_quad_reload_pwm.sv
module test_quad_reload_pwm;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int NC = 4;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic [NC-1:0] pwm_out;

    int checks = 0;
    int errors = 0;
    string cur_tag = "";

    // reference state
    int           m_cnt;
    int           m_reload;
    int           m_duty [NC];
    int           m_cmp  [NC];
    logic [NC-1:0] m_en;
    logic [NC-1:0] m_pol;

    quad_reload_pwm #(.CNT_W(CW), .NUM_CH(NC), .ADDR_W(AW)) i_quad_reload_pwm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic exp_out(int i);
        logic below;
        below = (m_cnt <= m_cmp[i]);
        return m_en[i] & (below ^ m_pol[i]);
    endfunction

    function automatic int exp_rd(int a);
        if (a == 0) return int'({m_en, m_pol});
        if (a == 1) return m_reload;
        if (a >= 4 && a < 4 + NC) return m_duty[a-4];
        return 0;
    endfunction

    function automatic string out_tag(int i);
        if (cur_tag != "") return cur_tag;
        if (!m_en[i]) return "R8";
        return m_pol[i] ? "R7" : "R6";
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_reload = 0; m_en = '0; m_pol = '0;
        for (int i = 0; i < NC; i++) begin
            m_duty[i] = 0; m_cmp[i] = 0;
        end
    endtask

    // one clock: drive, update reference at the edge, compare at the falling edge
    task automatic step(logic w, int a, int d, logic t);
        wr_en = w; addr = AW'(a); wdata = CW'(d); tick_en = t;
        @(posedge clk);
        if (t) begin
            if (m_cnt == 255) begin
                m_cnt = m_reload;
                for (int i = 0; i < NC; i++) m_cmp[i] = m_duty[i];
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        if (w) begin
            if (a == 0) begin
                m_en = d[7:4]; m_pol = d[3:0];
            end else if (a == 1) begin
                m_reload = d & 255;
            end else if (a >= 4 && a < 4 + NC) begin
                m_duty[a-4] = d & 255;
            end
        end
        @(negedge clk);
        for (int i = 0; i < NC; i++)
            check(out_tag(i), int'(pwm_out[i]), int'(exp_out(i)));
        check((cur_tag != "") ? cur_tag : "R2", int'(rdata), exp_rd(a));
    endtask

    int   period;
    logic prev;

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(pwm_out), 0);
        rst_n = 1'b1;
        cur_tag = "R1";
        step(0, 0, 0, 0);
        step(0, 1, 0, 0);
        step(0, 4, 0, 0);
        step(0, 7, 0, 0);

        // R2: map and readback, unmapped ignored
        cur_tag = "R2";
        step(1, 1, 8'hF0, 0);
        step(1, 4, 8'hF7, 0);
        step(1, 5, 8'h33, 0);
        step(1, 2, 8'hAA, 0);
        check("R2", int'(rdata), 0);
        step(1, 3, 8'h55, 0);
        step(0, 1, 0, 0);
        check("R2", int'(rdata), 8'hF0);
        step(1, 0, 8'h30, 0);
        check("R2", int'(rdata), 8'h30);

        // R3: counter holds without ticks (outputs must not move)
        cur_tag = "R3";
        for (int k = 0; k < 20; k++) step(0, 0, 0, 0);
        for (int k = 0; k < 300; k++) step(0, 0, 0, 1);

        // R4: period measured on channel 0 equals 256 - F0 = 16
        cur_tag = "R4";
        prev = pwm_out[0];
        while (!(pwm_out[0] && !prev)) begin
            prev = pwm_out[0];
            step(0, 0, 0, 1);
        end
        period = 0;
        prev = pwm_out[0];
        do begin
            prev = pwm_out[0];
            step(0, 0, 0, 1);
            period++;
        end while (!(pwm_out[0] && !prev));
        check("R4", period, 16);

        // R5: mid-period duty change waits for the reload
        cur_tag = "R5";
        for (int k = 0; k < 3; k++) step(0, 0, 0, 1);
        step(1, 4, 8'hF1, 1);
        for (int k = 0; k < 40; k++) step(0, 0, 0, 1);

        // R9: polarity flips act on the next cycle
        cur_tag = "R9";
        step(1, 5, 8'hFF, 1);
        for (int k = 0; k < 20; k++) step(0, 0, 0, 1);
        step(1, 0, 8'h32, 0);
        check("R9", int'(pwm_out[1]), 0);
        step(1, 0, 8'h30, 0);
        check("R9", int'(pwm_out[1]), 1);

        // R8: disabled channel low for both polarities
        cur_tag = "R8";
        step(1, 0, 8'h0F, 1);
        for (int k = 0; k < 40; k++) step(0, 0, 0, 1);
        check("R8", int'(pwm_out), 0);

        // R10: compare below reload -> always low; FFh -> always high
        cur_tag = "R10";
        step(1, 1, 8'h80, 1);
        step(1, 6, 8'h10, 1);
        step(1, 7, 8'hFF, 1);
        step(1, 0, 8'hC0, 1);
        for (int k = 0; k < 300; k++) step(0, 0, 0, 1);
        for (int k = 0; k < 200; k++) begin
            step(0, 0, 0, 1);
            check("R10", int'(pwm_out[2]), 0);
            check("R10", int'(pwm_out[3]), 1);
        end

        // random mix
        cur_tag = "";
        for (int k = 0; k < 6000; k++) begin
            automatic logic w = ($urandom % 4) == 0;
            automatic int   a = $urandom % 8;
            automatic int   d = $urandom % 256;
            automatic logic t = ($urandom % 4) != 0;
            step(w, a, d, t);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        process p;
        p = process::self();
        p.srandom(32'd20240611);
    end

endmodule